// File: doc/BRIEF.md
# Programmable Double-Pulse Generator

This block is a clocked source of digital test pulses. A free-running counter sets the repetition period. In the first cycle of every period the block raises a one-cycle sync marker on its own output. A main pulse follows after a programmable delay and lasts a programmable number of cycles. In paired mode, a second pulse of the same width follows after a programmable gap. The main output can be positive-going or negative-going.

Software writes shadow settings through a small write-only register port. The running pattern takes a new set of settings only at a period boundary, so no pulse already in progress is cut short. A settings set whose pattern does not fit inside the period is flagged as an error, and the pulse outputs stay inactive while it is in use.

Top module: `dpulse_gen`

## Requirements
- R1: After reset, `sync_o`, `pulse_o` and `cfg_err_o` are all low.
- R2: With a valid settings set, `sync_o` is high for exactly one cycle at count zero and repeats every PERIOD cycles.
- R3: The first pulse becomes active DELAY cycles after the cycle in which `sync_o` is high (DELAY 0 means the same cycle).
- R4: Each pulse is active for exactly WIDTH consecutive cycles.
- R5: In paired mode a second pulse starts GAP cycles after the first pulse ends, with the same width.
- R6: With the negative-polarity bit set, `pulse_o` idles high and goes low while active.
- R7: Register addresses: 0 PERIOD, 1 DELAY, 2 WIDTH, 3 GAP, 4 control (bit 0 paired mode, bit 1 negative polarity). A write to any other address has no effect.
- R8: Settings written during a period take effect only from the next period boundary. A pulse in progress keeps its old width.
- R9: If DELAY+WIDTH (plus GAP+WIDTH in paired mode) is not less than PERIOD, `cfg_err_o` is high during that period, `sync_o` stays low, and `pulse_o` stays at its inactive level.
- R10: While `enable` is low, `pulse_o` holds the inactive level of the written polarity and `sync_o` is low. After `enable` rises, the count restarts at zero and `sync_o` is high after the second rising edge at which `enable` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| sync_o | output | 1 | One-cycle marker at the start of each period |
| pulse_o | output | 1 | Main pulse output |
| cfg_err_o | output | 1 | Settings in use do not fit the period |

## Verification
A shadow write lands on the edge where `cfg_we` is sampled. A period boundary loads the active set on an edge, and every output appears one edge after the count and active set that produce it. So a setting written k cycles before a boundary shows up on the outputs one cycle after that boundary. The bench model follows the same order at each edge: outputs from the old state, then the load from the old shadow, then the write. It compares all three outputs at every falling edge. Directed measurements count falling edges from the `sync_o` cycle to the pulse edges.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam logic [2:0] ADDR_PERIOD = 3'd0;
  localparam logic [2:0] ADDR_DELAY  = 3'd1;
  localparam logic [2:0] ADDR_WIDTH  = 3'd2;
  localparam logic [2:0] ADDR_GAP    = 3'd3;
  localparam logic [2:0] ADDR_CTRL   = 3'd4;

  typedef struct packed {
    logic neg;
    logic paired;
  } ctrl_t;
endpackage

// File: rtl/dpg_regs.sv
module dpg_regs
  import dpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] sh_period,
  output logic [CNT_W-1:0] sh_delay,
  output logic [CNT_W-1:0] sh_width,
  output logic [CNT_W-1:0] sh_gap,
  output ctrl_t            sh_ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_period <= '0;
      sh_delay  <= '0;
      sh_width  <= '0;
      sh_gap    <= '0;
      sh_ctrl   <= '0;
    end else if (we) begin
      case (addr)
        ADDR_PERIOD: sh_period <= wdata;
        ADDR_DELAY:  sh_delay  <= wdata;
        ADDR_WIDTH:  sh_width  <= wdata;
        ADDR_GAP:    sh_gap    <= wdata;
        ADDR_CTRL:   sh_ctrl   <= ctrl_t'(wdata[1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dpg_timebase.sv
module dpg_timebase
  import dpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] sh_period,
  input  logic [CNT_W-1:0] sh_delay,
  input  logic [CNT_W-1:0] sh_width,
  input  logic [CNT_W-1:0] sh_gap,
  input  ctrl_t            sh_ctrl,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_delay,
  output logic [CNT_W-1:0] act_width,
  output logic [CNT_W-1:0] act_gap,
  output ctrl_t            act_ctrl,
  output logic             act_ok
);
  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] span;
  logic             sh_ok;
  logic             wrap;

  always_comb begin
    span = SUM_W'(sh_delay) + SUM_W'(sh_width);
    if (sh_ctrl.paired) span = span + SUM_W'(sh_gap) + SUM_W'(sh_width);
    sh_ok = span < SUM_W'(sh_period);
    wrap  = (SUM_W'(cnt) + SUM_W'(1)) >= SUM_W'(act_period);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      cnt        <= '0;
      act_period <= '0;
      act_delay  <= '0;
      act_width  <= '0;
      act_gap    <= '0;
      act_ctrl   <= '0;
      act_ok     <= 1'b0;
    end else if (!enable) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run || wrap) begin
      run        <= 1'b1;
      cnt        <= '0;
      act_period <= sh_period;
      act_delay  <= sh_delay;
      act_width  <= sh_width;
      act_gap    <= sh_gap;
      act_ctrl   <= sh_ctrl;
      act_ok     <= sh_ok;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    (run && act_ok) |-> (cnt < act_period));
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0));
  assert_load_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != '0) |-> ($stable(act_width) && $stable(act_delay) && $stable(act_ctrl)));
endmodule

// File: rtl/dpg_shaper.sv
module dpg_shaper
  import dpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] act_delay,
  input  logic [CNT_W-1:0] act_width,
  input  logic [CNT_W-1:0] act_gap,
  input  ctrl_t            act_ctrl,
  input  logic             act_ok,
  input  logic             idle_neg,
  output logic             sync_q,
  output logic             pulse_q,
  output logic             err_q
);
  localparam int SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] c, s1, e1, s2, e2;
  logic             win1, win2, active, neg_sel;

  always_comb begin
    c       = SUM_W'(cnt);
    s1      = SUM_W'(act_delay);
    e1      = s1 + SUM_W'(act_width);
    s2      = e1 + SUM_W'(act_gap);
    e2      = s2 + SUM_W'(act_width);
    win1    = (c >= s1) && (c < e1);
    win2    = act_ctrl.paired && (c >= s2) && (c < e2);
    active  = run && act_ok && (win1 || win2);
    neg_sel = run ? act_ctrl.neg : idle_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sync_q  <= run && act_ok && (cnt == '0);
      pulse_q <= active ^ neg_sel;
      err_q   <= run && !act_ok;
    end
  end

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !sync_q);
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pulse_q == $past(idle_neg)) && !sync_q && !err_q);
endmodule

// File: rtl/dpulse_gen.sv
module dpulse_gen
  import dpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             sync_o,
  output logic             pulse_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] sh_period, sh_delay, sh_width, sh_gap;
  ctrl_t            sh_ctrl;
  logic             run, act_ok;
  logic [CNT_W-1:0] cnt, act_period, act_delay, act_width, act_gap;
  ctrl_t            act_ctrl;

  dpg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sh_period(sh_period), .sh_delay(sh_delay), .sh_width(sh_width),
    .sh_gap(sh_gap), .sh_ctrl(sh_ctrl)
  );

  dpg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .enable(enable),
    .sh_period(sh_period), .sh_delay(sh_delay), .sh_width(sh_width),
    .sh_gap(sh_gap), .sh_ctrl(sh_ctrl),
    .run(run), .cnt(cnt), .act_period(act_period), .act_delay(act_delay),
    .act_width(act_width), .act_gap(act_gap), .act_ctrl(act_ctrl), .act_ok(act_ok)
  );

  dpg_shaper #(.CNT_W(CNT_W)) u_shp (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt),
    .act_delay(act_delay), .act_width(act_width), .act_gap(act_gap),
    .act_ctrl(act_ctrl), .act_ok(act_ok), .idle_neg(sh_ctrl.neg),
    .sync_q(sync_o), .pulse_q(pulse_o), .err_q(cfg_err_o)
  );
endmodule

// File: tb/dpulse_gen_tb.sv
module dpulse_gen_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst, enable, cfg_we;
  logic [2:0] cfg_addr;
  logic [CNT_W-1:0] cfg_wdata;
  logic sync_o, pulse_o, cfg_err_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dpulse_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sync_o(sync_o), .pulse_o(pulse_o), .cfg_err_o(cfg_err_o)
  );

  // Behavioural reference
  int s_per, s_dly, s_wid, s_gap; bit s_pair, s_neg;
  int a_per, a_dly, a_wid, a_gap; bit a_pair, a_neg, a_ok;
  bit m_run; int m_cnt;
  bit e_sync, e_pulse, e_err;

  always @(posedge clk) begin
    if (rst) begin
      s_per = 0; s_dly = 0; s_wid = 0; s_gap = 0; s_pair = 0; s_neg = 0;
      a_per = 0; a_dly = 0; a_wid = 0; a_gap = 0; a_pair = 0; a_neg = 0; a_ok = 0;
      m_run = 0; m_cnt = 0; e_sync = 0; e_pulse = 0; e_err = 0;
    end else begin
      bit act;
      act = 0;
      if (m_run && a_ok) begin
        if (m_cnt >= a_dly && m_cnt < a_dly + a_wid) act = 1;
        if (a_pair && m_cnt >= a_dly + a_wid + a_gap &&
            m_cnt < a_dly + 2*a_wid + a_gap) act = 1;
      end
      e_sync  = m_run && a_ok && m_cnt == 0;
      e_err   = m_run && !a_ok;
      e_pulse = act ^ (m_run ? a_neg : s_neg);
      if (!enable) begin
        m_run = 0; m_cnt = 0;
      end else if (!m_run || m_cnt + 1 >= a_per) begin
        m_run = 1; m_cnt = 0;
        a_per = s_per; a_dly = s_dly; a_wid = s_wid; a_gap = s_gap;
        a_pair = s_pair; a_neg = s_neg;
        a_ok = (s_dly + s_wid + (s_pair ? s_gap + s_wid : 0)) < s_per;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: s_per = int'(cfg_wdata);
          3'd1: s_dly = int'(cfg_wdata);
          3'd2: s_wid = int'(cfg_wdata);
          3'd3: s_gap = int'(cfg_wdata);
          3'd4: begin s_pair = cfg_wdata[0]; s_neg = cfg_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) begin
    if (compare_on) begin
      chk(cur_req, "sync_o", int'(sync_o), int'(e_sync));
      chk(cur_req, "pulse_o", int'(pulse_o), int'(e_pulse));
      chk(cur_req, "cfg_err_o", int'(cfg_err_o), int'(e_err));
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CNT_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int per, input int dly, input int wid, input int gap, input int ctrl);
    wr(3'd0, per); wr(3'd1, dly); wr(3'd2, wid); wr(3'd3, gap); wr(3'd4, ctrl);
  endtask

  // Measures, from the sync cycle, the cycles to each edge of the pulse.
  task automatic measure(input bit neg, output int to_rise, output int len,
                         output int to_second, output int per);
    int n;
    n = 0;
    while (sync_o !== 1'b1 && n < 500) begin @(negedge clk); n++; end
    to_rise = 0;
    while ((pulse_o ^ neg) !== 1'b1 && to_rise < 500) begin @(negedge clk); to_rise++; end
    len = 0;
    while ((pulse_o ^ neg) === 1'b1 && len < 500) begin @(negedge clk); len++; end
    to_second = to_rise + len;
    while ((pulse_o ^ neg) !== 1'b1 && sync_o !== 1'b1 && to_second < 500) begin
      @(negedge clk); to_second++;
    end
    per = to_second;
    while (sync_o !== 1'b1 && per < 500) begin @(negedge clk); per++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r, l, s, p;
    rst = 1'b1; enable = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "sync after reset", int'(sync_o), 0);
    chk("R1", "pulse after reset", int'(pulse_o), 0);
    chk("R1", "err after reset", int'(cfg_err_o), 0);
    compare_on = 1;

    // R2 R3 R4 single positive pulse
    cur_req = "R2";
    setup(12, 3, 2, 0, 0);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    compare_on = 0;
    measure(1'b0, r, l, s, p);
    chk("R3", "delay cycles", r, 3);
    chk("R4", "width cycles", l, 2);
    chk("R2", "period cycles", p, 12);
    compare_on = 1;

    // R3 delay zero coincides with sync
    cur_req = "R3";
    setup(9, 0, 3, 0, 0);
    repeat (30) @(negedge clk);
    compare_on = 0;
    measure(1'b0, r, l, s, p);
    chk("R3", "zero delay", r, 0);
    chk("R4", "width 3", l, 3);
    compare_on = 1;

    // R5 paired mode
    cur_req = "R5";
    setup(20, 2, 3, 4, 1);
    repeat (45) @(negedge clk);
    compare_on = 0;
    measure(1'b0, r, l, s, p);
    chk("R5", "second pulse start", s, 2 + 3 + 4);
    chk("R2", "paired period", p, 20);
    compare_on = 1;

    // R8 write mid-period: width changes during the pulse
    cur_req = "R8";
    compare_on = 0;
    setup(16, 4, 3, 0, 0);
    repeat (40) @(negedge clk);
    while (sync_o !== 1'b1) @(negedge clk);
    compare_on = 1;
    repeat (4) @(negedge clk);
    wr(3'd2, 6);
    repeat (40) @(negedge clk);
    compare_on = 0;
    measure(1'b0, r, l, s, p);
    chk("R8", "new width after boundary", l, 6);
    compare_on = 1;

    // R6 negative polarity, paired
    cur_req = "R6";
    setup(14, 1, 2, 1, 3);
    repeat (35) @(negedge clk);
    compare_on = 0;
    measure(1'b1, r, l, s, p);
    chk("R6", "negative low width", l, 2);
    chk("R6", "negative delay", r, 1);
    compare_on = 1;

    // R7 write to unused address ignored
    cur_req = "R7";
    wr(3'd6, 0);
    wr(3'd7, 5);
    repeat (35) @(negedge clk);
    compare_on = 0;
    measure(1'b1, r, l, s, p);
    chk("R7", "width unchanged", l, 2);
    chk("R7", "period unchanged", p, 14);
    compare_on = 1;

    // R9 invalid: 3+2 not below 5
    cur_req = "R9";
    setup(5, 3, 2, 0, 0);
    repeat (20) @(negedge clk);
    chk("R9", "err flag", int'(cfg_err_o), 1);
    chk("R9", "pulse inactive", int'(pulse_o), 0);
    setup(8, 1, 2, 3, 1);
    repeat (20) @(negedge clk);
    chk("R9", "paired overflow err", int'(cfg_err_o), 1);
    setup(8, 1, 2, 2, 1);
    repeat (20) @(negedge clk);
    chk("R9", "paired fits", int'(cfg_err_o), 0);

    // R10 disable with negative polarity, then restart
    cur_req = "R10";
    wr(3'd4, 2);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10", "idle level negative", int'(pulse_o), 1);
    chk("R10", "sync low disabled", int'(sync_o), 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R10", "no sync one edge after enable", int'(sync_o), 0);
    @(negedge clk);
    chk("R10", "sync two edges after enable", int'(sync_o), 1);
    repeat (30) @(negedge clk);

    compare_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule